// File: doc/BRIEF.md
# Sync-Referenced Video Timing Generator

This block produces the horizontal and vertical raster timing for a display pipe. Both of its counters reset to zero at the leading edge of the sync pulse rather than at the first visible pixel, so every window is a position measured forward from sync. Each programmable position carries a fixed offset that matches the latency of the pixel pipe behind the generator. The horizontal positions are even, and the horizontal period is a multiple of four pixels.

Software writes timing values into a pending register set through a simple write port. The whole pending set is copied into the active set in one step at the frame boundary, so a mid-frame update never splits a frame between two configurations. The outputs are both sync pulses with programmable polarity, a display-enable, a border-enable for the blanking border around the picture, a cursor-window flag and the live pixel and line counts. A control register holds a global video enable and the two polarity selects.

Top module: `video_timing_gen`

## Requirements
- R1: After reset both counts are 0 and every active and pending register is 0. The raster is then 8 pixels by 1 line, hsync and vsync are high, and display-enable, border-enable and cursor are low.
- R2: The pixel count runs from 0 to (hTotal with bits 1:0 cleared)+7 and then returns to 0. The line count advances by one when the pixel count wraps.
- R3: The line count runs from 0 to vTotal and returns to 0 when the pixel count wraps on line vTotal. That wrap is the frame boundary.
- R4: The internal horizontal sync is active while pixCount < (hSync with bit 0 cleared)+8. The hsync pin carries that value XOR control bit 16.
- R5: The internal vertical sync is active while lineCount < vSync+1. The vsync pin carries that value XOR control bit 18.
- R6: dispEn is high when all three of these hold: control bit 12 is set; pixCount lies in [hDispStart+18, hDispEnd+18); lineCount lies in [vDispStart+1, vDispEnd+1). Horizontal values have bit 0 cleared first.
- R7: bordEn is high when control bit 12 is set, pixCount lies in [hBordStart+12, hBordEnd+12), lineCount lies in [vBordStart+1, vBordEnd+1) and dispEn is low. Horizontal values have bit 0 cleared. dispEn and bordEn are never high together.
- R8: cursorOn is high when control bit 12 is set, pixCount lies in [hCurStart+17, hCurStart+17+CURSOR_W) and lineCount lies in [vCurStart, vCurEnd). hCurStart uses all of its bits.
- R9: A register write changes only the pending set. The active set, and with it every output, changes only at the first frame boundary after the write.
- R10: With control bit 12 clear, dispEn, bordEn and cursorOn stay low while both syncs keep running. Writing 0 to the control register therefore blanks the picture.
- R11: hTotal bits 1:0 have no effect, and bit 0 of hSync, hDispStart, hDispEnd, hBordStart and hBordEnd has no effect. The horizontal period is always a multiple of 4.
- R12: Write addresses are as follows. Horizontal: 0 total, 1 sync, 2 display start, 3 display end, 4 border start, 5 border end, 6 cursor start. Control: 7. Vertical: 8 total, 9 sync, 10 display start, 11 display end, 12 border start, 13 border end, 14 cursor start, 15 cursor end. The low HW (horizontal) or VW (vertical) data bits are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Write strobe for the pending register set |
| regAddr | input | 4 | Register address |
| regData | input | DW | Write data |
| pixCount | output | HW+1 | Pixel position from the hsync leading edge |
| lineCount | output | VW | Line position from the vsync leading edge |
| hsync | output | 1 | Horizontal sync, polarity per control bit 16 |
| vsync | output | 1 | Vertical sync, polarity per control bit 18 |
| dispEn | output | 1 | Active picture window |
| bordEn | output | 1 | Border window outside the picture |
| cursorOn | output | 1 | Cursor window |

## Verification
The checks on counter stepping and on the active configuration staying fixed inside a frame assume a few things about the writes. The field widths must hold the programmed horizontal positions plus their offsets, and every window end must not precede its start. The positions must also lie inside the programmed period. The stimulus meets these assumptions by programming one small raster of 68 pixels by 10 lines with ordered windows. It then changes only the display start and the control register, in the middle of a frame, and observes the change only from the following frame.

// File: rtl/vtg_pkg.sv
`timescale 1ns/1ps
package vtg_pkg;
  localparam int ADDR_W = 4;
  localparam int H_NUM  = 7;
  localparam int V_NUM  = 8;

  // horizontal field index equals its address
  localparam int H_TOT   = 0;
  localparam int H_SYNC  = 1;
  localparam int H_DSP_S = 2;
  localparam int H_DSP_E = 3;
  localparam int H_BRD_S = 4;
  localparam int H_BRD_E = 5;
  localparam int H_CUR_S = 6;

  // vertical field index equals address minus V_ADDR_BASE
  localparam int V_TOT   = 0;
  localparam int V_SYNC  = 1;
  localparam int V_DSP_S = 2;
  localparam int V_DSP_E = 3;
  localparam int V_BRD_S = 4;
  localparam int V_BRD_E = 5;
  localparam int V_CUR_S = 6;
  localparam int V_CUR_E = 7;

  localparam int V_ADDR_BASE = 8;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 4'd7;

  localparam int CTL_EN_BIT   = 12;
  localparam int CTL_HINV_BIT = 16;
  localparam int CTL_VINV_BIT = 18;

  // pipeline offsets from the sync leading edge
  localparam int OFS_PERIOD  = 8;
  localparam int OFS_SYNC    = 8;
  localparam int OFS_BORDER  = 12;
  localparam int OFS_DISPLAY = 18;
  localparam int OFS_CURSOR  = 17;

  typedef struct packed {
    logic lineEnd;
    logic frameEnd;
  } vtgStrobe_t;

  typedef struct packed {
    logic vInv;
    logic hInv;
    logic en;
  } vtgCtrl_t;
endpackage

// File: rtl/vtg_ctrl.sv
`timescale 1ns/1ps
module vtg_ctrl
  import vtg_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [HW:0]   hLast,
  input  logic [VW-1:0] vLast,
  output logic [HW:0]   pixCount,
  output logic [VW-1:0] lineCount,
  output vtgStrobe_t    strb
);
  logic lineEnd;
  logic frameEnd;

  assign lineEnd  = (pixCount >= hLast);
  assign frameEnd = lineEnd && (lineCount >= vLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixCount  <= '0;
      lineCount <= '0;
    end else if (lineEnd) begin
      pixCount  <= '0;
      lineCount <= frameEnd ? '0 : lineCount + 1'b1;
    end else begin
      pixCount  <= pixCount + 1'b1;
    end
  end

  assign strb.lineEnd  = lineEnd;
  assign strb.frameEnd = frameEnd;
endmodule

// File: rtl/vtg_regs.sv
`timescale 1ns/1ps
module vtg_regs
  import vtg_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11,
  parameter int DW = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       we,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DW-1:0]              data,
  input  vtgStrobe_t                 strb,
  output logic [H_NUM-1:0][HW-1:0]   hAct,
  output logic [V_NUM-1:0][VW-1:0]   vAct,
  output vtgCtrl_t                   ctrlAct
);
  logic [H_NUM-1:0][HW-1:0] hPend;
  logic [V_NUM-1:0][VW-1:0] vPend;
  vtgCtrl_t                 ctrlPend;
  vtgCtrl_t                 ctrlWord;

  assign ctrlWord.en   = data[CTL_EN_BIT];
  assign ctrlWord.hInv = data[CTL_HINV_BIT];
  assign ctrlWord.vInv = data[CTL_VINV_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hPend    <= '0;
      vPend    <= '0;
      ctrlPend <= '0;
      hAct     <= '0;
      vAct     <= '0;
      ctrlAct  <= '0;
    end else begin
      // the frame copy sees the pending set from before this edge
      if (strb.frameEnd) begin
        hAct    <= hPend;
        vAct    <= vPend;
        ctrlAct <= ctrlPend;
      end
      if (we) begin
        for (int i = 0; i < H_NUM; i++)
          if (addr == ADDR_W'(i)) hPend[i] <= data[HW-1:0];
        for (int i = 0; i < V_NUM; i++)
          if (addr == ADDR_W'(V_ADDR_BASE + i)) vPend[i] <= data[VW-1:0];
        if (addr == ADDR_CTRL) ctrlPend <= ctrlWord;
      end
    end
  end

  logic unusedIn;
  assign unusedIn = ^{data, strb.lineEnd};
endmodule

// File: rtl/vtg_datapath.sv
`timescale 1ns/1ps
module vtg_datapath
  import vtg_pkg::*;
#(
  parameter int HW       = 12,
  parameter int VW       = 11,
  parameter int CURSOR_W = 32
) (
  input  logic [HW:0]                pixCount,
  input  logic [VW-1:0]              lineCount,
  input  logic [H_NUM-1:0][HW-1:0]   hAct,
  input  logic [V_NUM-1:0][VW-1:0]   vAct,
  input  vtgCtrl_t                   ctrlAct,
  output logic [HW:0]                hLast,
  output logic [VW-1:0]              vLast,
  output logic                       hsync,
  output logic                       vsync,
  output logic                       dispEn,
  output logic                       bordEn,
  output logic                       cursorOn
);
  localparam int HCW = HW + 1;
  localparam int VCW = VW + 1;

  function automatic logic [HCW-1:0] evenPos(input logic [HW-1:0] v, input int unsigned ofs);
    return {1'b0, v[HW-1:1], 1'b0} + HCW'(ofs);
  endfunction

  function automatic logic [VCW-1:0] linePos(input logic [VW-1:0] v);
    return {1'b0, v} + VCW'(1);
  endfunction

  logic [VCW-1:0] lineX;
  logic hSyncRaw, vSyncRaw;
  logic hDisp, hBord, hCur;
  logic vDisp, vBord, vCur;
  logic [HCW-1:0] curStart;
  logic inDisp;

  assign lineX    = {1'b0, lineCount};
  assign hLast    = {1'b0, hAct[H_TOT][HW-1:2], 2'b00} + HCW'(OFS_PERIOD - 1);
  assign vLast    = vAct[V_TOT];

  assign hSyncRaw = pixCount < evenPos(hAct[H_SYNC], OFS_SYNC);
  assign vSyncRaw = lineX < linePos(vAct[V_SYNC]);

  assign hDisp = (pixCount >= evenPos(hAct[H_DSP_S], OFS_DISPLAY)) &&
                 (pixCount <  evenPos(hAct[H_DSP_E], OFS_DISPLAY));
  assign hBord = (pixCount >= evenPos(hAct[H_BRD_S], OFS_BORDER)) &&
                 (pixCount <  evenPos(hAct[H_BRD_E], OFS_BORDER));
  assign curStart = {1'b0, hAct[H_CUR_S]} + HCW'(OFS_CURSOR);
  assign hCur  = (pixCount >= curStart) && (pixCount < curStart + HCW'(CURSOR_W));

  assign vDisp = (lineX >= linePos(vAct[V_DSP_S])) && (lineX < linePos(vAct[V_DSP_E]));
  assign vBord = (lineX >= linePos(vAct[V_BRD_S])) && (lineX < linePos(vAct[V_BRD_E]));
  assign vCur  = (lineCount >= vAct[V_CUR_S]) && (lineCount < vAct[V_CUR_E]);

  assign inDisp   = hDisp && vDisp;
  assign hsync    = hSyncRaw ^ ctrlAct.hInv;
  assign vsync    = vSyncRaw ^ ctrlAct.vInv;
  assign dispEn   = ctrlAct.en && inDisp;
  assign bordEn   = ctrlAct.en && hBord && vBord && !inDisp;
  assign cursorOn = ctrlAct.en && hCur && vCur;

  logic unusedLow;
  assign unusedLow = ^{hAct[H_TOT][1:0], hAct[H_SYNC][0], hAct[H_DSP_S][0],
                       hAct[H_DSP_E][0], hAct[H_BRD_S][0], hAct[H_BRD_E][0]};
endmodule

// File: rtl/video_timing_gen.sv
`timescale 1ns/1ps
module video_timing_gen
  import vtg_pkg::*;
#(
  parameter int HW       = 12,
  parameter int VW       = 11,
  parameter int DW       = 32,
  parameter int CURSOR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DW-1:0]     regData,
  output logic [HW:0]       pixCount,
  output logic [VW-1:0]     lineCount,
  output logic              hsync,
  output logic              vsync,
  output logic              dispEn,
  output logic              bordEn,
  output logic              cursorOn
);
  vtgStrobe_t               strb;
  logic [H_NUM-1:0][HW-1:0] hAct;
  logic [V_NUM-1:0][VW-1:0] vAct;
  vtgCtrl_t                 ctrlAct;
  logic [HW:0]              hLast;
  logic [VW-1:0]            vLast;

  vtg_ctrl #(.HW(HW), .VW(VW)) u_ctrl (
    .clk(clk), .rstN(rstN), .hLast(hLast), .vLast(vLast),
    .pixCount(pixCount), .lineCount(lineCount), .strb(strb)
  );

  vtg_regs #(.HW(HW), .VW(VW), .DW(DW)) u_regs (
    .clk(clk), .rstN(rstN), .we(regWe), .addr(regAddr), .data(regData),
    .strb(strb), .hAct(hAct), .vAct(vAct), .ctrlAct(ctrlAct)
  );

  vtg_datapath #(.HW(HW), .VW(VW), .CURSOR_W(CURSOR_W)) u_dp (
    .pixCount(pixCount), .lineCount(lineCount), .hAct(hAct), .vAct(vAct),
    .ctrlAct(ctrlAct), .hLast(hLast), .vLast(vLast), .hsync(hsync),
    .vsync(vsync), .dispEn(dispEn), .bordEn(bordEn), .cursorOn(cursorOn)
  );
endmodule

// File: rtl/vtg_checker.sv
`timescale 1ns/1ps
module vtg_checker
  import vtg_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [HW:0]              pixCount,
  input logic [VW-1:0]            lineCount,
  input logic                     dispEn,
  input logic                     bordEn,
  input logic                     cursorOn,
  input logic                     cfgEn,
  input logic [H_NUM-1:0][HW-1:0] hCfg,
  input logic [V_NUM-1:0][VW-1:0] vCfg
);
  // R2: the pixel count only ever steps by one or wraps to zero
  p_pix_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    pixCount != '0 |-> pixCount == $past(pixCount) + 1'b1);

  // R3: the line count holds except on the pixel wrap
  p_line_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    pixCount != '0 |-> $stable(lineCount));

  // R7: picture and border never overlap
  p_disp_border_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    dispEn |-> !bordEn);

  // R9: the active configuration moves only into the first frame position
  p_cfg_frame_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(pixCount == '0 && lineCount == '0) |-> ($stable(hCfg) && $stable(vCfg)));

  // R10: windows are quiet while video is disabled
  p_blank_r10: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEn |-> (!dispEn && !bordEn && !cursorOn));

  // R11: the line always wraps after a count ending in binary 11
  p_period_mult4_r11: assert property (@(posedge clk) disable iff (!rstN)
    (pixCount == '0 && $past(pixCount) != '0) |-> $past(pixCount[1:0]) == 2'b11);
endmodule

bind video_timing_gen vtg_checker #(.HW(HW), .VW(VW)) u_chk (
  .clk(clk), .rstN(rstN), .pixCount(pixCount), .lineCount(lineCount),
  .dispEn(dispEn), .bordEn(bordEn), .cursorOn(cursorOn), .cfgEn(ctrlAct.en),
  .hCfg(hAct), .vCfg(vAct)
);

// File: tb/video_timing_gen_tb.sv
`timescale 1ns/1ps
module video_timing_gen_tb;
  localparam int HW = 12;
  localparam int VW = 11;
  localparam int DW = 32;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [3:0] regAddr = '0;
  logic [DW-1:0] regData = '0;
  logic [HW:0] pixCount;
  logic [VW-1:0] lineCount;
  logic hsync, vsync, dispEn, bordEn, cursorOn;

  always #2.5 clk = ~clk;

  video_timing_gen #(.HW(HW), .VW(VW), .DW(DW), .CURSOR_W(CW)) u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regData(regData),
    .pixCount(pixCount), .lineCount(lineCount), .hsync(hsync), .vsync(vsync),
    .dispEn(dispEn), .bordEn(bordEn), .cursorOn(cursorOn)
  );

  int nVec = 0;
  int nFail = 0;
  int cyc = 0;
  bit done = 0;
  bit live = 0;

  // behavioural reference state
  int hP[7], vP[8], cP;
  int hA[7], vA[8], cA;
  int mh, mv;

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (hP[i]) begin hP[i] = 0; hA[i] = 0; end
      foreach (vP[i]) begin vP[i] = 0; vA[i] = 0; end
      cP = 0; cA = 0; mh = 0; mv = 0;
      live = 1;
    end else begin
      bit lineE, frameE;
      lineE  = (mh >= ((hA[0] & ~3) + 7));
      frameE = lineE && (mv >= vA[0]);
      if (lineE) begin
        mh = 0;
        mv = frameE ? 0 : mv + 1;
      end else mh = mh + 1;
      if (frameE) begin hA = hP; vA = vP; cA = cP; end
      if (regWe) begin
        if (regAddr < 7) hP[regAddr] = int'(regData) & 'hFFF;
        else if (regAddr == 7) cP = int'(regData) & ((1 << 12) | (1 << 16) | (1 << 18));
        else vP[regAddr - 8] = int'(regData) & 'h7FF;
      end
    end
  end

  function automatic int inH(int lo, int hi); return int'(mh >= lo && mh < hi); endfunction
  function automatic int inV(int lo, int hi); return int'(mv >= lo && mv < hi); endfunction
  function automatic int en(); return (cA >> 12) & 1; endfunction
  function automatic int eHs(); return int'(mh < ((hA[1] & ~1) + 8)) ^ ((cA >> 16) & 1); endfunction
  function automatic int eVs(); return int'(mv < vA[1] + 1) ^ ((cA >> 18) & 1); endfunction
  function automatic int eDisp();
    return en() & inH((hA[2] & ~1) + 18, (hA[3] & ~1) + 18) & inV(vA[2] + 1, vA[3] + 1);
  endfunction
  function automatic int eBord();
    return en() & inH((hA[4] & ~1) + 12, (hA[5] & ~1) + 12) & inV(vA[4] + 1, vA[5] + 1)
           & (1 - (inH((hA[2] & ~1) + 18, (hA[3] & ~1) + 18) & inV(vA[2] + 1, vA[3] + 1)));
  endfunction
  function automatic int eCur();
    return en() & inH(hA[6] + 17, hA[6] + 17 + CW) & inV(vA[6], vA[7]);
  endfunction

  task automatic cmp(string what, int act, int exp);
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic chk(string what, int act, int exp);
    nVec++;
    cmp(what, act, exp);
  endtask

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (rstN && live && !done) begin
      nVec++;
      cmp("R2 pixCount", int'(pixCount), mh);
      cmp("R3 lineCount", int'(lineCount), mv);
      cmp("R4 hsync", int'(hsync), eHs());
      cmp("R5 vsync", int'(vsync), eVs());
      cmp("R6 dispEn", int'(dispEn), eDisp());
      cmp("R7 bordEn", int'(bordEn), eBord());
      cmp("R8 cursorOn", int'(cursorOn), eCur());
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nFail++;
      $display("FAIL watchdog: run hung actual=%0d expected=%0d", cyc, 150000);
      finishRun();
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    regWe = 1'b1; regAddr = 4'(a); regData = DW'(d);
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic waitPos(int h, int v);
    for (int n = 0; n < 5000; n++) begin
      @(negedge clk);
      if (int'(pixCount) == h && int'(lineCount) == v) return;
    end
    nFail++;
    $display("FAIL R2 position not reached actual=%0d expected=%0d", int'(pixCount), h);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    chk("R1 pixCount", int'(pixCount), 0);
    chk("R1 lineCount", int'(lineCount), 0);
    chk("R1 hsync", int'(hsync), 1);
    chk("R1 vsync", int'(vsync), 1);
    chk("R1 dispEn", int'(dispEn), 0);
    chk("R1 bordEn", int'(bordEn), 0);
    chk("R1 cursorOn", int'(cursorOn), 0);
    @(negedge clk);
    chk("R1 pixCount step", int'(pixCount), 1);

    // R12: program a 68 x 10 raster through the address map
    wr(0, 62);  wr(1, 9);   wr(2, 4);   wr(3, 41);
    wr(4, 1);   wr(5, 51);  wr(6, 20);
    wr(8, 9);   wr(9, 0);   wr(10, 2);  wr(11, 6);
    wr(12, 1);  wr(13, 7);  wr(14, 4);  wr(15, 6);
    wr(7, 1 << 12);
    waitPos(0, 0); waitPos(0, 0); waitPos(0, 0);

    waitPos(5, 0);
    chk("R4 hsync inside pulse", int'(hsync), 1);
    chk("R5 vsync on line 0", int'(vsync), 1);
    waitPos(16, 0);
    chk("R4 hsync after even width", int'(hsync), 0);
    waitPos(67, 0);
    @(negedge clk);
    chk("R11 period 68 wraps pixel", int'(pixCount), 0);
    chk("R2 line advances on wrap", int'(lineCount), 1);
    waitPos(5, 1);
    chk("R5 vsync ends after one line", int'(vsync), 0);
    waitPos(11, 2);
    chk("R7 before border start", int'(bordEn), 0);
    waitPos(12, 2);
    chk("R11 border start low bit ignored", int'(bordEn), 1);
    waitPos(30, 2);
    chk("R7 border line above picture", int'(bordEn), 1);
    chk("R6 no picture on line 2", int'(dispEn), 0);
    waitPos(21, 3);
    chk("R6 before display start", int'(dispEn), 0);
    chk("R7 border left of picture", int'(bordEn), 1);
    waitPos(22, 3);
    chk("R6 display start", int'(dispEn), 1);
    chk("R7 border excluded in picture", int'(bordEn), 0);
    waitPos(57, 3);
    chk("R6 last display pixel", int'(dispEn), 1);
    waitPos(58, 3);
    chk("R11 display end low bit ignored", int'(dispEn), 0);
    waitPos(62, 3);
    chk("R7 border end", int'(bordEn), 0);
    waitPos(36, 4);
    chk("R8 before cursor", int'(cursorOn), 0);
    waitPos(37, 4);
    chk("R8 cursor start", int'(cursorOn), 1);
    waitPos(44, 4);
    chk("R8 cursor last pixel", int'(cursorOn), 1);
    waitPos(45, 4);
    chk("R8 cursor width end", int'(cursorOn), 0);
    waitPos(40, 5);
    chk("R8 cursor line 5", int'(cursorOn), 1);
    waitPos(40, 6);
    chk("R8 cursor end line exclusive", int'(cursorOn), 0);
    waitPos(67, 9);
    @(negedge clk);
    chk("R3 frame wrap line", int'(lineCount), 0);
    chk("R3 frame wrap pixel", int'(pixCount), 0);

    // R9: mid-frame write of display start (address 2)
    waitPos(30, 3);
    wr(2, 10);
    waitPos(25, 4);
    chk("R9 old display start kept this frame", int'(dispEn), 1);
    waitPos(25, 3);
    chk("R9 new display start next frame", int'(dispEn), 0);
    waitPos(28, 3);
    chk("R12 address 2 is display start", int'(dispEn), 1);

    // R10: blank by writing zero to control
    waitPos(0, 1);
    wr(7, 0);
    waitPos(0, 0);
    waitPos(30, 4);
    chk("R10 picture blanked", int'(dispEn), 0);
    waitPos(40, 5);
    chk("R10 cursor blanked", int'(cursorOn), 0);
    waitPos(5, 6);
    chk("R10 hsync still running", int'(hsync), 1);
    waitPos(30, 7);
    chk("R10 border blanked", int'(bordEn), 0);

    // R4/R5: inverted polarities with video back on
    wr(7, (1 << 12) | (1 << 16) | (1 << 18));
    waitPos(0, 0);
    waitPos(5, 0);
    chk("R4 inverted hsync in pulse", int'(hsync), 0);
    chk("R5 inverted vsync in pulse", int'(vsync), 0);
    waitPos(20, 1);
    chk("R4 inverted hsync idle", int'(hsync), 1);
    chk("R5 inverted vsync idle", int'(vsync), 1);
    waitPos(28, 3);
    chk("R10 video enabled again", int'(dispEn), 1);

    waitPos(0, 0);
    finishRun();
  end
endmodule